// File: doc/BRIEF.md
# SPI Word Queue Pair with Occupancy Status

This block buffers data words between a host register port and a serial shift engine. It holds two independent first-in first-out queues of 16 words of 32 bits each. The host loads outgoing words into one queue, and the shift engine drains them from the head. The engine fills the other queue with incoming words, and the host unloads them from its head. Each queue keeps a live fill count. Both counts are packed into one status word together with two sticky fault bits.

A configuration word sets a programmable threshold for each direction. The receive threshold can be reloaded before every transfer, down to the exact number of words still expected, so that even a short transfer raises the receive flag. Two bits of the same word flush one queue or the other. Each queue tracks its occupancy with a three-state machine. The states are Q_EMPTY, Q_PARTIAL and Q_FULL. The transitions are:
- Q_EMPTY to Q_PARTIAL on an accepted push.
- Q_PARTIAL to Q_FULL on a lone push at 15 words.
- Q_PARTIAL to Q_EMPTY on a lone pop at one word.
- Q_FULL to Q_PARTIAL on a pop.
- Any state to Q_EMPTY on a flush.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each queue holds up to 16 words. `status_word` reports the receive fill count (0 to 16) in bits 12:8 and the transmit fill count in bits 20:16. These counts reflect every push and pop accepted at the preceding clock edges.
- R2: Both queues keep first-in first-out order. `eng_tx_data` shows the oldest transmit word and `host_rx_rdata` shows the oldest receive word whenever that queue is not empty. A pop advances to the next word.
- R3: A `cfg_wr` pulse loads the receive threshold from `cfg_wdata[3:0]` and the transmit threshold from `cfg_wdata[7:4]`. `cfg_rdata` returns the receive threshold in bits 3:0, the transmit threshold in bits 7:4, and zero in all other bits.
- R4: `rx_thr_flag` is high while the receive count is at or above the receive threshold. `tx_thr_flag` is high while the transmit count is at or below the transmit threshold.
- R5: A `cfg_wr` with bit 11 set empties the receive queue, and one with bit 12 set empties the transmit queue. The flush takes effect at that edge and overrides any push or pop on the same queue in that cycle. It leaves the other queue untouched. It is a pulse that never reads back.
- R6: A host write while the transmit queue is full is dropped and sets the sticky fault at `status_word[0]`. Only a transmit flush clears that fault.
- R7: A host read while the receive queue is empty is dropped and sets the sticky fault at `status_word[1]`. Only a receive flush clears that fault.
- R8: When a push and a pop are both accepted on the same queue in one cycle, its count stays the same.
- R9: `eng_tx_avail` is high exactly while the transmit queue holds a word. `eng_rx_space` is high exactly while the receive queue is not full. An engine pop on an empty queue or push on a full queue has no effect and raises no fault.
- R10: After reset both queues are empty, both faults are clear, the transmit threshold is 4 and the receive threshold is 12, so `cfg_rdata` reads 0x4C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_tx_wr | input | 1 | Host pushes `host_tx_wdata` into the transmit queue |
| host_tx_wdata | input | 32 | Word written by the host |
| host_rx_rd | input | 1 | Host pops the receive queue head |
| host_rx_rdata | output | 32 | Receive queue head |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Thresholds and flush bits |
| cfg_rdata | output | 32 | Threshold readback |
| status_word | output | 32 | Fill counts and sticky faults |
| rx_thr_flag | output | 1 | Receive count at or above threshold |
| tx_thr_flag | output | 1 | Transmit count at or below threshold |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 32 | Transmit queue head |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers `eng_rx_data` |
| eng_rx_data | input | 32 | Word received by the engine |
| eng_rx_space | output | 1 | Receive queue not full |

## Verification
The assertions check the following on every cycle:
- The counts stay within range.
- A flush empties its queue at the next edge and clears that queue's fault.
- A dropped host access sets its fault, and the fault then stays set.
- A paired push and pop holds the count.
- The receive flag and the engine-side status match the reported counts.

Only the bench scenarios can show the word order through each queue, the threshold values taken from configuration writes, and the exact fill counts under mixed traffic. The bench compares all of these with a reference model of its own.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_t;

    localparam int RXTHR_LSB   = 0;
    localparam int TXTHR_LSB   = 4;
    localparam int RXFLUSH_BIT = 11;
    localparam int TXFLUSH_BIT = 12;
    localparam int RXCNT_LSB   = 8;
    localparam int TXCNT_LSB   = 16;
    localparam int TXOVF_BIT   = 0;
    localparam int RXUNF_BIT   = 1;
endpackage

// File: rtl/spi_fifo_queue.sv
module spi_fifo_queue
    import spi_fifo_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          is_empty,
    output logic          is_full
);
    localparam logic [CW-1:0] LAST_FREE = CW'(DEPTH - 1);
    localparam logic [AW-1:0] PTR_MAX   = AW'(DEPTH - 1);

    qstate_t       state, state_nxt;
    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push && (state != Q_FULL)  && !flush;
    assign do_pop  = pop  && (state != Q_EMPTY) && !flush;

    always_comb begin
        state_nxt = state;
        if (flush) begin
            state_nxt = Q_EMPTY;
        end else begin
            unique case (state)
                Q_EMPTY:   if (do_push) state_nxt = (DEPTH == 1) ? Q_FULL : Q_PARTIAL;
                Q_PARTIAL: begin
                    if (do_push && !do_pop && count == LAST_FREE)
                        state_nxt = Q_FULL;
                    else if (do_pop && !do_push && count == CW'(1))
                        state_nxt = Q_EMPTY;
                end
                Q_FULL:    if (do_pop) state_nxt = (DEPTH == 1) ? Q_EMPTY : Q_PARTIAL;
                default:   state_nxt = Q_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + AW'(1);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    always_comb begin
        is_empty = (state == Q_EMPTY);
        is_full  = (state == Q_FULL);
        head     = store[rd_ptr];
    end
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TW         = 4,
    parameter int TX_THR_RST = 4,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [31:0]   cfg_wdata,
    input  logic          host_tx_wr,
    input  logic          tx_full,
    input  logic          host_rx_rd,
    input  logic          rx_empty,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    output logic          rx_flush,
    output logic          tx_flush,
    output logic [TW-1:0] rx_thr,
    output logic [TW-1:0] tx_thr,
    output logic          rx_thr_flag,
    output logic          tx_thr_flag,
    output logic          tx_ovf,
    output logic          rx_unf
);
    localparam logic [TW-1:0] TX_THR_INIT = TW'(TX_THR_RST);
    localparam logic [TW-1:0] RX_THR_INIT = TW'(DEPTH - TX_THR_RST);

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[31:13], cfg_wdata[10:8]};

    assign rx_flush = cfg_wr && cfg_wdata[RXFLUSH_BIT];
    assign tx_flush = cfg_wr && cfg_wdata[TXFLUSH_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_thr <= RX_THR_INIT;
            tx_thr <= TX_THR_INIT;
        end else if (cfg_wr) begin
            rx_thr <= cfg_wdata[RXTHR_LSB +: TW];
            tx_thr <= cfg_wdata[TXTHR_LSB +: TW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ovf <= 1'b0;
            rx_unf <= 1'b0;
        end else begin
            if (tx_flush)                     tx_ovf <= 1'b0;
            else if (host_tx_wr && tx_full)   tx_ovf <= 1'b1;
            if (rx_flush)                     rx_unf <= 1'b0;
            else if (host_rx_rd && rx_empty)  rx_unf <= 1'b1;
        end
    end

    always_comb begin
        rx_thr_flag = (rx_count >= CW'(rx_thr));
        tx_thr_flag = (tx_count <= CW'(tx_thr));
    end
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int DW         = 32,
    parameter int DEPTH      = 16,
    parameter int TW         = 4,
    parameter int TX_THR_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_tx_wr,
    input  logic [DW-1:0] host_tx_wdata,
    input  logic          host_rx_rd,
    output logic [DW-1:0] host_rx_rdata,
    input  logic          cfg_wr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic [31:0]   status_word,
    output logic          rx_thr_flag,
    output logic          tx_thr_flag,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    output logic          eng_tx_avail,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    output logic          eng_rx_space
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] rx_count, tx_count;
    logic          rx_empty, rx_full, tx_empty, tx_full;
    logic          rx_flush, tx_flush, tx_ovf, rx_unf;
    logic [TW-1:0] rx_thr, tx_thr;

    spi_fifo_queue #(.DW(DW), .DEPTH(DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(host_tx_wr), .push_data(host_tx_wdata),
        .pop(eng_tx_pop), .head(eng_tx_data),
        .count(tx_count), .is_empty(tx_empty), .is_full(tx_full)
    );

    spi_fifo_queue #(.DW(DW), .DEPTH(DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(host_rx_rd), .head(host_rx_rdata),
        .count(rx_count), .is_empty(rx_empty), .is_full(rx_full)
    );

    spi_fifo_ctrl #(.DEPTH(DEPTH), .TW(TW), .TX_THR_RST(TX_THR_RST)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .host_tx_wr(host_tx_wr), .tx_full(tx_full),
        .host_rx_rd(host_rx_rd), .rx_empty(rx_empty),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_flush(rx_flush), .tx_flush(tx_flush),
        .rx_thr(rx_thr), .tx_thr(tx_thr),
        .rx_thr_flag(rx_thr_flag), .tx_thr_flag(tx_thr_flag),
        .tx_ovf(tx_ovf), .rx_unf(rx_unf)
    );

    always_comb begin
        status_word                     = '0;
        status_word[RXCNT_LSB +: CW]    = rx_count;
        status_word[TXCNT_LSB +: CW]    = tx_count;
        status_word[TXOVF_BIT]          = tx_ovf;
        status_word[RXUNF_BIT]          = rx_unf;
        cfg_rdata                       = '0;
        cfg_rdata[RXTHR_LSB +: TW]      = rx_thr;
        cfg_rdata[TXTHR_LSB +: TW]      = tx_thr;
        eng_tx_avail                    = !tx_empty;
        eng_rx_space                    = !rx_full;
    end
endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_tx_wr,
    input logic        host_rx_rd,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [31:0] status_word,
    input logic        rx_thr_flag,
    input logic        eng_tx_pop,
    input logic        eng_tx_avail,
    input logic        eng_rx_push,
    input logic        eng_rx_space
);
    logic [4:0] rxc, txc;
    logic       fl_rx, fl_tx;
    assign rxc   = status_word[12:8];
    assign txc   = status_word[20:16];
    assign fl_rx = cfg_wr && cfg_wdata[11];
    assign fl_tx = cfg_wr && cfg_wdata[12];

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rxc <= 5'd16) && (txc <= 5'd16)); // R1
    AST_RX_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_thr_flag == (rxc >= {1'b0, cfg_rdata[3:0]})); // R4
    AST_TX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fl_tx |=> (txc == 5'd0) && !status_word[0]); // R5
    AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rx |=> (rxc == 5'd0) && !status_word[1]); // R5
    AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        host_tx_wr && (txc == 5'd16) && !fl_tx |=> status_word[0]); // R6
    AST_TX_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[0] && !fl_tx |=> status_word[0]); // R6
    AST_RX_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        host_rx_rd && (rxc == 5'd0) && !fl_rx |=> status_word[1]); // R7
    AST_TX_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        host_tx_wr && eng_tx_pop && (txc != 5'd0) && (txc != 5'd16) && !fl_tx
        |=> $stable(txc)); // R8
    AST_RX_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_push && host_rx_rd && (rxc != 5'd0) && (rxc != 5'd16) && !fl_rx
        |=> $stable(rxc)); // R8
    AST_ENG_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_avail == (txc != 5'd0)) && (eng_rx_space == (rxc != 5'd16))); // R9
endmodule

bind spi_fifo_pair spi_fifo_pair_chk chk_i (
    .clk(clk), .rst_n(rst_n), .host_tx_wr(host_tx_wr), .host_rx_rd(host_rx_rd),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .status_word(status_word), .rx_thr_flag(rx_thr_flag),
    .eng_tx_pop(eng_tx_pop), .eng_tx_avail(eng_tx_avail),
    .eng_rx_push(eng_rx_push), .eng_rx_space(eng_rx_space)
);

// File: tb/spi_fifo_pair_tb_top.sv
module spi_fifo_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_tx_wr = 1'b0;
    logic [31:0] host_tx_wdata = '0;
    logic        host_rx_rd = 1'b0;
    logic [31:0] host_rx_rdata;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] status_word;
    logic        rx_thr_flag, tx_thr_flag;
    logic        eng_tx_pop = 1'b0;
    logic [31:0] eng_tx_data;
    logic        eng_tx_avail;
    logic        eng_rx_push = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        eng_rx_space;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mtx[$];
    logic [31:0] mrx[$];
    logic [3:0]  m_rthr = 4'd12;
    logic [3:0]  m_tthr = 4'd4;
    bit          m_ovf = 1'b0;
    bit          m_unf = 1'b0;

    always #2 clk = ~clk;

    spi_fifo_pair dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_tx_wr(host_tx_wr), .host_tx_wdata(host_tx_wdata),
        .host_rx_rd(host_rx_rd), .host_rx_rdata(host_rx_rdata),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .status_word(status_word), .rx_thr_flag(rx_thr_flag), .tx_thr_flag(tx_thr_flag),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_space(eng_rx_space)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_cfg();
        return {24'd0, m_tthr, m_rthr};
    endfunction

    task automatic compare_all();
        int rs = mrx.size();
        int ts = mtx.size();
        chk(status_word[12:8] == 5'(rs), "R1 rx count", status_word[12:8], rs);
        chk(status_word[20:16] == 5'(ts), "R1 tx count", status_word[20:16], ts);
        chk(status_word[0] == m_ovf, "R6 tx overflow fault", status_word[0], m_ovf);
        chk(status_word[1] == m_unf, "R7 rx underflow fault", status_word[1], m_unf);
        chk(cfg_rdata == exp_cfg(), "R3 cfg readback", cfg_rdata, exp_cfg());
        chk(rx_thr_flag == (rs >= int'(m_rthr)), "R4 rx flag", rx_thr_flag, rs >= int'(m_rthr));
        chk(tx_thr_flag == (ts <= int'(m_tthr)), "R4 tx flag", tx_thr_flag, ts <= int'(m_tthr));
        chk(eng_tx_avail == (ts != 0), "R9 tx avail", eng_tx_avail, ts != 0);
        chk(eng_rx_space == (rs != 16), "R9 rx space", eng_rx_space, rs != 16);
        if (ts != 0) chk(eng_tx_data == mtx[0], "R2 tx head", eng_tx_data, mtx[0]);
        if (rs != 0) chk(host_rx_rdata == mrx[0], "R2 rx head", host_rx_rdata, mrx[0]);
    endtask

    task automatic model_step();
        bit frx = cfg_wr && cfg_wdata[11];
        bit ftx = cfg_wr && cfg_wdata[12];
        if (ftx) begin
            mtx.delete();
            m_ovf = 1'b0;
        end else begin
            bit full = (mtx.size() == 16);
            bit emp  = (mtx.size() == 0);
            if (host_tx_wr && full) m_ovf = 1'b1;
            if (eng_tx_pop && !emp) void'(mtx.pop_front());
            if (host_tx_wr && !full) mtx.push_back(host_tx_wdata);
        end
        if (frx) begin
            mrx.delete();
            m_unf = 1'b0;
        end else begin
            bit full = (mrx.size() == 16);
            bit emp  = (mrx.size() == 0);
            if (host_rx_rd && emp) m_unf = 1'b1;
            if (host_rx_rd && !emp) void'(mrx.pop_front());
            if (eng_rx_push && !full) mrx.push_back(eng_rx_data);
        end
        if (cfg_wr) begin
            m_rthr = cfg_wdata[3:0];
            m_tthr = cfg_wdata[7:4];
        end
    endtask

    task automatic do_cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        host_tx_wr = 0; host_rx_rd = 0; cfg_wr = 0; eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int wr_pct = 50, pop_pct = 50, rxp_pct = 50, rd_pct = 50;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cfg_rdata == 32'h4C, "R10 reset thresholds", cfg_rdata, 32'h4C);
        chk(status_word == 32'd0, "R10 reset status", status_word, 0);
        compare_all();

        // R6: fill tx to 16, then one more write
        for (int i = 0; i < 17; i++) begin
            host_tx_wr = 1; host_tx_wdata = 32'hA000_0000 + i;
            do_cycle();
        end
        idle_inputs();
        chk(status_word[20:16] == 5'd16, "R6 tx stays full", status_word[20:16], 16);
        chk(status_word[0] == 1'b1, "R6 overflow sticky", status_word[0], 1);
        do_cycle();
        chk(status_word[0] == 1'b1, "R6 overflow still set", status_word[0], 1);

        // R5: tx flush with a same-cycle write and pop; rx untouched
        eng_rx_push = 1; eng_rx_data = 32'h5555_0001;
        do_cycle();
        idle_inputs();
        cfg_wr = 1; cfg_wdata = 32'h0000_104C; host_tx_wr = 1; eng_tx_pop = 1;
        do_cycle();
        idle_inputs();
        chk(status_word[20:16] == 5'd0, "R5 tx flush empties", status_word[20:16], 0);
        chk(status_word[0] == 1'b0, "R5 tx flush clears fault", status_word[0], 0);
        chk(status_word[12:8] == 5'd1, "R5 rx unaffected", status_word[12:8], 1);
        chk(cfg_rdata[12:8] == 5'd0, "R5 flush bits self clear", cfg_rdata[12:8], 0);

        // R8: simultaneous push and pop
        for (int i = 0; i < 5; i++) begin
            host_tx_wr = 1; host_tx_wdata = 32'hB000_0000 + i;
            do_cycle();
        end
        host_tx_wr = 1; eng_tx_pop = 1; host_tx_wdata = 32'hBEEF_0000;
        eng_rx_push = 1; host_rx_rd = 1; eng_rx_data = 32'h5555_0002;
        do_cycle();
        idle_inputs();
        chk(status_word[20:16] == 5'd5, "R8 tx count held", status_word[20:16], 5);
        chk(status_word[12:8] == 5'd1, "R8 rx count held", status_word[12:8], 1);

        // R7: read empty rx
        host_rx_rd = 1;
        do_cycle();
        do_cycle();
        idle_inputs();
        chk(status_word[1] == 1'b1, "R7 underflow sticky", status_word[1], 1);
        // R9: engine pop of an empty tx queue raises nothing
        cfg_wr = 1; cfg_wdata = 32'h0000_104C;
        do_cycle();
        idle_inputs();
        eng_tx_pop = 1;
        do_cycle();
        idle_inputs();
        chk(status_word[0] == 1'b0, "R9 empty pop no fault", status_word[0], 0);
        // R5: rx flush beats a same-cycle push; R3 thresholds reprogrammed
        cfg_wr = 1; cfg_wdata = 32'h0000_0802; eng_rx_push = 1; eng_rx_data = 32'h1;
        do_cycle();
        idle_inputs();
        chk(status_word[12:8] == 5'd0, "R5 rx flush wins", status_word[12:8], 0);
        chk(status_word[1] == 1'b0, "R5 rx flush clears fault", status_word[1], 0);
        chk(cfg_rdata == 32'h02, "R3 new thresholds", cfg_rdata, 32'h02);
        // R4: short-transfer receive threshold
        for (int i = 0; i < 2; i++) begin
            eng_rx_push = 1; eng_rx_data = 32'hC0 + i;
            do_cycle();
        end
        idle_inputs();
        chk(rx_thr_flag == 1'b1, "R4 rx flag at exact count", rx_thr_flag, 1);

        // Random traffic
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 250 == 0) begin
                wr_pct  = $urandom_range(90, 10);
                pop_pct = $urandom_range(90, 10);
                rxp_pct = $urandom_range(90, 10);
                rd_pct  = $urandom_range(90, 10);
            end
            host_tx_wr    = ($urandom_range(99) < wr_pct);
            host_tx_wdata = $urandom;
            eng_tx_pop    = ($urandom_range(99) < pop_pct);
            eng_rx_push   = ($urandom_range(99) < rxp_pct);
            eng_rx_data   = $urandom;
            host_rx_rd    = ($urandom_range(99) < rd_pct);
            cfg_wr        = ($urandom_range(99) < 2);
            cfg_wdata     = $urandom;
            do_cycle();
        end
        idle_inputs();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule